// File: doc/BRIEF.md
# Chainable Digital-Input Serializer

This block models an industrial input serializer. It filters eight digital inputs, takes a snapshot of them when a serial read begins, and shifts the snapshot out on a four-wire serial link with chip select, serial clock, serial data out and serial data in. A frame-width select input picks the frame. In the short frame only the input byte is sent. In the long frame each input byte is followed by a status byte. The status byte carries a 5-bit check code computed over the input byte, plus the supply and temperature flags.

Several instances can be chained. Each instance's serial output drives the serial input of the next one. Bits taken in on the serial input are shifted out right behind the instance's own word, so a single chip-select window reads every device in the chain. Each input has its own filter. A two-pin selector picks no filtering or one of three hold times, counted in system-clock ticks. A fault output goes low while overtemperature or an undervoltage alarm is present.

The serial clock and chip select are sampled by the system clock. Each serial-clock phase must therefore last at least two system-clock cycles.

Top module: `din_serializer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `fault_n` is 1 and `sdo` is 0.
- R2: The frame carries the filtered input values sampled at the clock edge that first sees `cs_n` low. Input changes after that edge do not alter the frame in progress.
- R3: With `frame8_sel` low, a frame is 16 bits sent MSB-first: the input byte (input 7 first), then the status byte. The first bit is on `sdo` before the first rising `sclk`. Each later bit appears after a rising `sclk`.
- R4: Status byte fields: bits 7..3 hold the check code, bit 2 is the inverse of `uv_alarm`, bit 1 equals `over_temp`, and bit 0 is the inverse of `uv_warn`.
- R5: The check code is the remainder of the input byte, fed MSB-first, under the generator x^5+x^4+x^2+1 (low terms 5'h15), starting from zero.
- R6: With `frame8_sel` high at the start of a frame, the frame is only the 8-bit input byte, MSB-first.
- R7: The bit on `sdi` at each rising `sclk` leaves on `sdo` exactly one own-word later: 16 rising edges later in the long frame, 8 in the short frame.
- R8: `deb_sel` is {first pin, second pin}. With 2'b00 (no filter), each filtered bit takes the raw input value one clock later.
- R9: With 2'b01, 2'b10 or 2'b11, a changed input is accepted only after it has differed from the filtered value on 25, 750 or 3000 times UNIT_TICKS consecutive clock edges. One edge fewer is rejected.
- R10: `fault_n` goes low one clock after `over_temp` or `uv_alarm` is high, and is high otherwise. `uv_warn` alone never pulls it low.
- R11: While `cs_n` is high, `sclk` edges do not shift the register, and `sdo` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| din | input | 8 | Raw digital inputs |
| deb_sel | input | 2 | Filter selector {first pin, second pin} |
| frame8_sel | input | 1 | High selects the 8-bit frame |
| uv_alarm | input | 1 | Undervoltage alarm, active high |
| uv_warn | input | 1 | Undervoltage warning, active high |
| over_temp | input | 1 | Overtemperature, active high |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock; shifts on its rising edge |
| sdi | input | 1 | Chain serial input |
| sdo | output | 1 | Serial data output |
| fault_n | output | 1 | Fault output, active low |

## Verification
The hardest cases to reach are the exact acceptance boundaries of the input filter. A change has to persist for precisely the selected hold count, or one edge fewer, and the only way to see the result is a later serial frame. The bench drives an input step for an exact number of clock edges from the falling clock edge, restores the input, and then reads a frame. It does this at the boundary for all three nonzero settings. Chained operation is reached by pushing a random word into `sdi` while reading twice the own-word length.

// File: rtl/din_ser_pkg.sv
package din_ser_pkg;
    localparam int DATA_W    = 8;
    localparam int CRC_W     = 5;
    localparam int FRAME_W   = 2 * DATA_W;
    localparam logic [CRC_W-1:0] CRC_POLY = 5'h15;
    localparam int LIM_SHORT = 25;
    localparam int LIM_MED   = 750;
    localparam int LIM_LONG  = 3000;

    typedef enum logic [1:0] {
        DB_NONE  = 2'b00,
        DB_SHORT = 2'b01,
        DB_MED   = 2'b10,
        DB_LONG  = 2'b11
    } db_sel_e;

    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic               cs_q;
        logic               sclk_q;
        logic               mode8_q;
    } shift_state_t;
endpackage

// File: rtl/din_debounce.sv
module din_debounce
    import din_ser_pkg::*;
#(
    parameter int W          = 8,
    parameter int UNIT_TICKS = 100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    input  db_sel_e      sel,
    output logic [W-1:0] filt
);
    localparam int MAXC = LIM_LONG * UNIT_TICKS;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          val;
    } db_bit_t;

    logic [CW-1:0] thresh;

    always_comb begin
        case (sel)
            DB_SHORT: thresh = CW'(LIM_SHORT * UNIT_TICKS);
            DB_MED:   thresh = CW'(LIM_MED * UNIT_TICKS);
            DB_LONG:  thresh = CW'(LIM_LONG * UNIT_TICKS);
            default:  thresh = '0;
        endcase
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        db_bit_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (sel == DB_NONE) begin
                st_d.val = raw[i];
                st_d.cnt = '0;
            end else if (raw[i] == st_q.val) begin
                st_d.cnt = '0;
            end else if (st_q.cnt + CW'(1) >= thresh) begin
                st_d.val = raw[i];
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign filt[i] = st_q.val;
    end
endmodule

// File: rtl/din_crc5.sv
module din_crc5
    import din_ser_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc
);
    always_comb begin
        logic [CRC_W-1:0] r;
        logic             fb;
        r = '0;
        for (int k = DATA_W - 1; k >= 0; k--) begin
            fb = r[CRC_W-1] ^ data[k];
            r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        crc = r;
    end
endmodule

// File: rtl/din_frame_shift.sv
module din_frame_shift
    import din_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              mode8,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] status,
    output logic              sdo
);
    shift_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.cs_q   = cs_n;
        st_d.sclk_q = sclk;
        if (!cs_n && st_q.cs_q) begin
            st_d.mode8_q = mode8;
            st_d.shreg   = mode8 ? {{DATA_W{1'b0}}, data} : {data, status};
        end else if (!cs_n && sclk && !st_q.sclk_q) begin
            st_d.shreg = {st_q.shreg[FRAME_W-2:0], sdi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.cs_q   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo = st_q.mode8_q ? st_q.shreg[DATA_W-1] : st_q.shreg[FRAME_W-1];
endmodule

// File: rtl/din_serializer.sv
module din_serializer
    import din_ser_pkg::*;
#(
    parameter int UNIT_TICKS = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] din,
    input  logic [1:0] deb_sel,
    input  logic       frame8_sel,
    input  logic       uv_alarm,
    input  logic       uv_warn,
    input  logic       over_temp,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       sdi,
    output logic       sdo,
    output logic       fault_n
);
    logic [DATA_W-1:0] filt;
    logic [CRC_W-1:0]  crc;
    logic [DATA_W-1:0] status;
    logic              fault_d, fault_q;

    din_debounce #(.W(DATA_W), .UNIT_TICKS(UNIT_TICKS)) u_deb (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (din),
        .sel   (db_sel_e'(deb_sel)),
        .filt  (filt)
    );

    din_crc5 u_crc (
        .data (filt),
        .crc  (crc)
    );

    assign status = {crc, ~uv_alarm, over_temp, ~uv_warn};

    din_frame_shift u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sclk   (sclk),
        .sdi    (sdi),
        .mode8  (frame8_sel),
        .data   (filt),
        .status (status),
        .sdo    (sdo)
    );

    always_comb begin
        fault_d = !(over_temp || uv_alarm);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= 1'b1;
        else        fault_q <= fault_d;
    end

    assign fault_n = fault_q;
endmodule

// File: rtl/din_serializer_chk.sv
module din_serializer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] din,
    input logic [1:0] deb_sel,
    input logic       uv_alarm,
    input logic       over_temp,
    input logic       cs_n,
    input logic       sdo,
    input logic       fault_n,
    input logic [7:0] filt
);
    a_r1_reset_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fault_n && !sdo));

    a_r8_no_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (deb_sel == 2'b00) |=> (filt == $past(din)));

    a_r9_change_matches_input: assert property (@(posedge clk) disable iff (!rst_n)
        (filt != $past(filt)) |-> (((filt ^ $past(din)) & (filt ^ $past(filt))) == 8'h00));

    a_r10_fault_low: assert property (@(posedge clk) disable iff (!rst_n)
        (over_temp || uv_alarm) |=> !fault_n);

    a_r10_fault_high: assert property (@(posedge clk) disable iff (!rst_n)
        !(over_temp || uv_alarm) |=> fault_n);

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> $stable(sdo));
endmodule

bind din_serializer din_serializer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .deb_sel   (deb_sel),
    .uv_alarm  (uv_alarm),
    .over_temp (over_temp),
    .cs_n      (cs_n),
    .sdo       (sdo),
    .fault_n   (fault_n),
    .filt      (filt)
);

// File: tb/din_serializer_bench.sv
module din_serializer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int UNIT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'h00;
    logic [1:0] deb_sel = 2'b00;
    logic       frame8_sel = 1'b0;
    logic       uv_alarm = 1'b0, uv_warn = 1'b0, over_temp = 1'b0;
    logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic       sdo, fault_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    din_serializer #(.UNIT_TICKS(UNIT)) u_din_serializer (
        .clk(clk), .rst_n(rst_n), .din(din), .deb_sel(deb_sel),
        .frame8_sel(frame8_sel), .uv_alarm(uv_alarm), .uv_warn(uv_warn),
        .over_temp(over_temp), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .fault_n(fault_n)
    );

    function automatic logic [4:0] ref_crc(input logic [7:0] d);
        logic [4:0] r = 5'h00;
        for (int k = 7; k >= 0; k--) begin
            if (r[4] ^ d[k]) r = {r[3:0], 1'b0} ^ 5'h15;
            else             r = {r[3:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [15:0] ref_word(input logic [7:0] d, input logic uva,
                                             input logic ot, input logic uvw);
        return {d, ref_crc(d), ~uva, ot, ~uvw};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input int n, input logic [31:0] sdi_bits, input bit chg,
                        input logic [7:0] new_din, output logic [31:0] got);
        got = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
        if (chg) din = new_din;
        for (int i = 0; i < n; i++) begin
            got[n-1-i] = sdo;
            sdi  = sdi_bits[n-1-i];
            sclk = 1'b1;
            repeat (2) @(negedge clk);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic hold_din(input logic [7:0] v, input int edges, input logic [7:0] after);
        @(negedge clk) din = v;
        repeat (edges) @(negedge clk);
        din = after;
    endtask

    initial begin
        logic [31:0] got;
        logic [7:0]  d;
        logic [31:0] w;
        void'($urandom(32'h5eed));

        // R1: reset state with a flag raised
        over_temp = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 fault_n in reset", {31'b0, fault_n}, 32'd1);
        chk("R1 sdo in reset", {31'b0, sdo}, 32'd0);
        over_temp = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3/R4/R5: directed long frame
        din = 8'hA5; uv_warn = 1'b1;
        repeat (3) @(negedge clk);
        xfer(16, 32'h0, 1'b0, 8'h0, got);
        chk("R3 R4 R5 long frame A5", got, {16'h0, ref_word(8'hA5, 1'b0, 1'b0, 1'b1)});
        uv_warn = 1'b0;

        // R2: input change after capture has no effect on frame
        din = 8'h3C;
        repeat (3) @(negedge clk);
        xfer(16, 32'h0, 1'b1, 8'hC3, got);
        chk("R2 snapshot held", got, {16'h0, ref_word(8'h3C, 1'b0, 1'b0, 1'b0)});

        // R6: short frame
        frame8_sel = 1'b1;
        repeat (3) @(negedge clk);
        xfer(8, 32'h0, 1'b0, 8'h0, got);
        chk("R6 short frame", got, {24'h0, 8'hC3});

        // R7: chain in short mode
        xfer(16, 32'h0000_9E00, 1'b0, 8'h0, got);
        chk("R7 chain short", got, {16'h0, 8'hC3, 8'h9E});
        frame8_sel = 1'b0;

        // R10: fault output
        @(negedge clk) uv_warn = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 warn only no fault", {31'b0, fault_n}, 32'd1);
        uv_warn = 1'b0; uv_alarm = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 uv alarm fault", {31'b0, fault_n}, 32'd0);
        uv_alarm = 1'b0; over_temp = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 overtemp fault", {31'b0, fault_n}, 32'd0);
        over_temp = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 fault cleared", {31'b0, fault_n}, 32'd1);

        // R11: sclk ignored while cs_n high
        din = 8'hB2;
        repeat (3) @(negedge clk);
        xfer(0, 32'h0, 1'b0, 8'h0, got);
        chk("R11 first bit shown", {31'b0, sdo}, 32'd1);
        sdi = 1'b0;
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b1; repeat (2) @(negedge clk);
            sclk = 1'b0; repeat (2) @(negedge clk);
        end
        chk("R11 sdo held", {31'b0, sdo}, 32'd1);

        // Random frames (R3 R4 R5 R6 R7 R8 R10)
        for (int it = 0; it < 24; it++) begin
            d = 8'($urandom);
            w = $urandom;
            din = d;
            uv_alarm = 1'($urandom); uv_warn = 1'($urandom); over_temp = 1'($urandom);
            frame8_sel = 1'($urandom);
            repeat (3) @(negedge clk);
            chk("R10 random fault", {31'b0, fault_n}, {31'b0, !(uv_alarm || over_temp)});
            if (frame8_sel) begin
                xfer(16, {16'h0, w[15:0]}, 1'b0, 8'h0, got);
                chk("R6 R7 R8 random short", got, {16'h0, d, w[15:8]});
            end else begin
                xfer(32, w, 1'b0, 8'h0, got);
                chk("R3 R4 R5 R7 R8 random long",
                    got, {ref_word(d, uv_alarm, over_temp, uv_warn), w[31:16]});
            end
        end
        uv_alarm = 1'b0; uv_warn = 1'b0; over_temp = 1'b0; frame8_sel = 1'b1;

        // R9: filter boundaries
        din = 8'h00; deb_sel = 2'b00;
        repeat (3) @(negedge clk);
        deb_sel = 2'b01;
        hold_din(8'hFF, 25 * UNIT - 1, 8'h00);
        repeat (4) @(negedge clk);
        xfer(8, 32'h0, 1'b0, 8'h0, got);
        chk("R9 short reject", got, 32'h00);
        hold_din(8'hFF, 25 * UNIT, 8'hFF);
        xfer(8, 32'h0, 1'b0, 8'h0, got);
        chk("R9 short accept", got, 32'hFF);

        deb_sel = 2'b10;
        hold_din(8'h5A, 750 * UNIT - 1, 8'hFF);
        repeat (4) @(negedge clk);
        xfer(8, 32'h0, 1'b0, 8'h0, got);
        chk("R9 medium reject", got, 32'hFF);
        hold_din(8'h5A, 750 * UNIT, 8'h5A);
        xfer(8, 32'h0, 1'b0, 8'h0, got);
        chk("R9 medium accept", got, 32'h5A);

        deb_sel = 2'b11;
        hold_din(8'h81, 3000 * UNIT - 1, 8'h5A);
        repeat (4) @(negedge clk);
        xfer(8, 32'h0, 1'b0, 8'h0, got);
        chk("R9 long reject", got, 32'h5A);
        hold_din(8'h81, 3000 * UNIT, 8'h81);
        xfer(8, 32'h0, 1'b0, 8'h0, got);
        chk("R9 long accept", got, 32'h81);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule